// File: doc/BRIEF.md
# Retriggerable Counter-Based One-Shot

This block is a synchronous monostable pulse generator. A programmable number of clock cycles sets the pulse width, so no external timing network is needed. Three asynchronous control lines can start a pulse:

- a trigger that acts on its falling edge;
- a trigger that acts on its rising edge;
- an active-low clear.

Each trigger only acts while the other trigger sits at its enabling level. The release of the clear also fires a pulse when both triggers already sit at their enabling levels. The block drives a true pulse output and its complement.

All three control lines pass through two-flop synchronisers before edges are detected. A trigger that arrives during a pulse restarts the timing, which stretches the pulse. Pulling the clear low ends a pulse and locks out every trigger for as long as it stays low.

The width is sampled at the clock edge that acts on a trigger. A width of zero therefore gives no pulse, and a zero-width retrigger ends the current pulse.

Top module: `retrig_oneshot`

## Requirements
- R1: After reset, and whenever no trigger has fired, `pulse_o` is 0 and `pulse_n_o` is 1.
- R2: `pulse_n_o` is always the inverse of `pulse_o`.
- R3: A 1-to-0 change of `trig_fall_i` fires a pulse when `trig_rise_i` is 1 and `clr_n_i` is 1. The pulse is `width_i` cycles long. `pulse_o` rises in the cycle after the third rising clock edge that follows the input change.
- R4: A 0-to-1 change of `trig_rise_i` fires a pulse, with the same latency, when `trig_fall_i` is 0 and `clr_n_i` is 1.
- R5: A 0-to-1 change of `clr_n_i` fires a pulse when `trig_fall_i` is already 0 and `trig_rise_i` is already 1.
- R6: Any edge on `trig_rise_i` while `trig_fall_i` is 1, and any edge on `trig_fall_i` while `trig_rise_i` is 0, fires no pulse.
- R7: A valid trigger during a pulse reloads the count, so the pulse ends `width_i` cycles after the latest trigger takes effect.
- R8: While `clr_n_i` is 0, a running pulse ends three clock edges after the clear falls, and no trigger fires.
- R9: A trigger only acts when the synchronised clear is 1 in both the current and the previous sample. A trigger edge and a falling clear in the same cycle give no pulse.
- R10: `width_i` is sampled only at the edge where a trigger takes effect, so later changes do not alter a running pulse. A sampled width of 0 produces no pulse and ends any running pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trig_fall_i | input | 1 | Falling-edge trigger, asynchronous |
| trig_rise_i | input | 1 | Rising-edge trigger, asynchronous |
| clr_n_i | input | 1 | Active-low clear; its rising edge can also fire |
| width_i | input | WIDTH | Pulse width in clock cycles |
| pulse_o | output | 1 | True pulse output |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
Every result is due three rising clock edges after the input change: two synchroniser stages and one counter load. This holds for a trigger start, a retrigger reload and a clear kill alike. The bench drives its inputs on the falling edge and compares the outputs at the next falling edge. Its reference model pushes each applied input value through a three-deep history before acting on it, so every comparison lands in exactly the cycle the change is due. Pulse lengths are measured as runs of high samples and compared against lengths worked out by hand for the directed cases.

// File: rtl/os_pkg.sv
package os_pkg;
  // Synchronised view of the three control lines.
  typedef struct packed {
    logic clr_n;
    logic rise_trg;
    logic fall_trg;
  } os_lines_t;

  // Reset and idle level of each line: clear inactive, both triggers inhibiting.
  localparam os_lines_t OS_IDLE = '{clr_n: 1'b1, rise_trg: 1'b0, fall_trg: 1'b1};
  localparam int OS_NLINES = $bits(os_lines_t);
endpackage

// File: rtl/os_rst_sync.sv
module os_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/os_sync.sv
module os_sync #(
  parameter int              NBITS   = 3,
  parameter int              STAGES  = 2,
  parameter logic [NBITS-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] din,
  output logic [NBITS-1:0] dout
);
  logic [STAGES-1:0][NBITS-1:0] stage_q;
  logic [STAGES-1:0][NBITS-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RST_VAL}};
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/os_trig_qual.sv
module os_trig_qual
  import os_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  os_lines_t lines_s,
  output os_lines_t lines_p,
  output logic      fire
);
  os_lines_t prev_d;
  logic      clr_steady;
  logic      fall_ok;
  logic      rise_ok;
  logic      clr_ok;

  always_comb begin
    prev_d = lines_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lines_p <= OS_IDLE;
    else        lines_p <= prev_d;
  end

  always_comb begin
    clr_steady = lines_s.clr_n & lines_p.clr_n;
    fall_ok    = lines_p.fall_trg & ~lines_s.fall_trg & lines_s.rise_trg;
    rise_ok    = ~lines_p.rise_trg & lines_s.rise_trg & ~lines_s.fall_trg;
    clr_ok     = lines_s.clr_n & ~lines_p.clr_n & ~lines_s.fall_trg & lines_s.rise_trg;
    fire       = (clr_steady & (fall_ok | rise_ok)) | clr_ok;
  end
endmodule

// File: rtl/os_pulse_timer.sv
module os_pulse_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_hi,
  input  logic             fire,
  input  logic [WIDTH-1:0] width,
  output logic [WIDTH-1:0] cnt,
  output logic             q,
  output logic             qn
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;
  logic             q_q;
  logic             qn_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!clr_hi)           cnt_d = '0;
    else if (fire)         cnt_d = width;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
      qn_q  <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      q_q  <= (cnt_d != '0);
      qn_q <= (cnt_d == '0);
    end
  end

  assign cnt = cnt_q;
  assign q   = q_q;
  assign qn  = qn_q;
endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import os_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_fall_i,
  input  logic             trig_rise_i,
  input  logic             clr_n_i,
  input  logic [WIDTH-1:0] width_i,
  output logic             pulse_o,
  output logic             pulse_n_o
);
  logic             rst_sync_n;
  os_lines_t        lines_raw;
  os_lines_t        lines_s;
  os_lines_t        lines_p;
  logic             fire;
  logic [WIDTH-1:0] cnt;

  os_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    lines_raw.clr_n    = clr_n_i;
    lines_raw.rise_trg = trig_rise_i;
    lines_raw.fall_trg = trig_fall_i;
  end

  os_sync #(
    .NBITS   (OS_NLINES),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (OS_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (lines_raw),
    .dout  (lines_s)
  );

  os_trig_qual u_qual (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .lines_s (lines_s),
    .lines_p (lines_p),
    .fire    (fire)
  );

  os_pulse_timer #(.WIDTH(WIDTH)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_hi (lines_s.clr_n),
    .fire   (fire),
    .width  (width_i),
    .cnt    (cnt),
    .q      (pulse_o),
    .qn     (pulse_n_o)
  );
endmodule

// File: rtl/os_chk.sv
module os_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fall_s,
  input logic             rise_s,
  input logic             clr_s,
  input logic             fire,
  input logic [WIDTH-1:0] width,
  input logic [WIDTH-1:0] cnt,
  input logic             q,
  input logic             qn
);
  // R2
  comp_out_chk: assert property (@(posedge clk) disable iff (!rst_n) qn == ~q);

  // R8
  clr_kill_chk: assert property (@(posedge clk) disable iff (!rst_n) !clr_s |=> !q);

  // R9
  clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |-> clr_s);

  // R6
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n) fire |-> (!fall_s && rise_s));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && width != '0) |=> (q && cnt == $past(width)));

  // R10
  zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && width == '0) |=> !q);

  // R7
  countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && clr_s && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && cnt == '0) |=> !q);
endmodule

bind retrig_oneshot os_chk #(.WIDTH(WIDTH)) u_os_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .fall_s (lines_s.fall_trg),
  .rise_s (lines_s.rise_trg),
  .clr_s  (lines_s.clr_n),
  .fire   (fire),
  .width  (width_i),
  .cnt    (cnt),
  .q      (pulse_o),
  .qn     (pulse_n_o)
);

// File: tb/tb_retrig_oneshot.sv
module tb_retrig_oneshot;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         a, b, c;
  logic [W-1:0] w;
  logic         q, qn;

  always #4 clk = ~clk;

  retrig_oneshot #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .trig_fall_i(a), .trig_rise_i(b),
    .clr_n_i(c), .width_i(w), .pulse_o(q), .pulse_n_o(qn)
  );

  int    n_chk = 0, n_fail = 0;
  string req = "R1";
  bit    done = 1'b0;

  // reference model: three-deep history per line, then the count
  logic ma1, ma2, ma3, mb1, mb2, mb3, mc1, mc2, mc3;
  int   mcnt;
  int   hi_run, last_len, pulses;
  logic prev_q;

  function automatic void chk(bit ok, string r, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endfunction

  function automatic bit model_fire();
    bit steady;
    steady = mc2 && mc3;
    return (steady && ((ma3 && !ma2 && mb2) || (!mb3 && mb2 && !ma2)))
           || (mc2 && !mc3 && !ma2 && mb2);
  endfunction

  function automatic void model_idle();
    ma1 = 1; ma2 = 1; ma3 = 1;
    mb1 = 0; mb2 = 0; mb3 = 0;
    mc1 = 1; mc2 = 1; mc3 = 1;
    mcnt = 0; hi_run = 0; last_len = 0; pulses = 0; prev_q = 0;
  endfunction

  task automatic step(input logic na, input logic nb, input logic nc, input int nw);
    bit f;
    @(negedge clk);
    chk(q === (mcnt != 0), req, int'(q), int'(mcnt != 0));
    chk(qn === ~q, "R2", int'(qn), int'(~q));
    if (q) hi_run++;
    else if (hi_run != 0) begin last_len = hi_run; hi_run = 0; end
    if (q && !prev_q) pulses++;
    prev_q = q;
    a = na; b = nb; c = nc; w = nw[W-1:0];
    f = model_fire();
    if (!mc2)          mcnt = 0;
    else if (f)        mcnt = nw;
    else if (mcnt != 0) mcnt--;
    ma3 = ma2; ma2 = ma1; ma1 = na;
    mb3 = mb2; mb2 = mb1; mb1 = nb;
    mc3 = mc2; mc2 = mc1; mc1 = nc;
  endtask

  task automatic hold(input int n);
    for (int i = 0; i < n; i++) step(a, b, c, int'(w));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin : main
    int p0, seed;
    rst_n = 1'b0; a = 1; b = 0; c = 1; w = 8'd5;
    model_idle();
    repeat (4) @(negedge clk);
    chk(q === 1'b0, "R1", int'(q), 0);
    chk(qn === 1'b1, "R1", int'(qn), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(q === 1'b0, "R1", int'(q), 0);
    req = "R1"; hold(4);

    // R6: rising trigger while falling trigger is high does nothing
    req = "R6"; p0 = pulses;
    step(1, 1, 1, 5); hold(8);
    chk(pulses == p0, "R6", pulses, p0);
    // R3: falling trigger with rising trigger high
    req = "R3";
    step(0, 1, 1, 5); hold(12);
    chk(last_len == 5, "R3", last_len, 5);
    step(1, 0, 1, 5); hold(4);

    // R6: falling trigger while rising trigger low does nothing
    req = "R6"; p0 = pulses;
    step(0, 0, 1, 9); hold(8);
    chk(pulses == p0, "R6", pulses, p0);
    // R4: rising trigger with falling trigger low
    req = "R4";
    step(0, 1, 1, 9); hold(14);
    chk(last_len == 9, "R4", last_len, 9);

    // R7: retrigger five edges later, width 6 -> 5 + 6
    req = "R7";
    step(0, 0, 1, 6); hold(3);
    step(0, 1, 1, 6); hold(3); step(0, 0, 1, 6); step(0, 1, 1, 6); hold(16);
    chk(last_len == 11, "R7", last_len, 11);

    // R10: zero-width retrigger ends the pulse after five cycles
    req = "R10";
    step(0, 0, 1, 10); hold(3);
    step(0, 1, 1, 10); hold(3); step(0, 0, 1, 10); step(0, 1, 1, 0); hold(16);
    chk(last_len == 5, "R10", last_len, 5);
    // R10: width changed after the load does not alter the pulse
    step(0, 0, 1, 4); hold(3);
    step(0, 1, 1, 4); hold(2); step(0, 1, 1, 12); hold(16);
    chk(last_len == 4, "R10", last_len, 4);
    // R10: zero width gives no pulse
    p0 = pulses;
    step(0, 0, 1, 0); hold(3); step(0, 1, 1, 0); hold(10);
    chk(pulses == p0, "R10", pulses, p0);

    // R8: clear five edges after trigger kills the pulse
    req = "R8";
    step(0, 0, 1, 20); hold(3);
    step(0, 1, 1, 20); hold(4); step(0, 1, 0, 20); hold(6);
    chk(last_len == 5, "R8", last_len, 5);
    chk(q === 1'b0, "R8", int'(q), 0);
    // R8: triggers ignored while clear is low
    p0 = pulses;
    step(1, 1, 0, 20); step(0, 1, 0, 20); step(0, 0, 0, 20); step(0, 1, 0, 20); hold(8);
    chk(pulses == p0, "R8", pulses, p0);

    // R5: releasing the clear with both triggers enabling fires
    req = "R5";
    step(0, 1, 1, 7); hold(12);
    chk(last_len == 7, "R5", last_len, 7);

    // R9: trigger edge and clear fall in the same cycle
    req = "R9";
    step(1, 1, 1, 7); hold(10); p0 = pulses;
    step(0, 1, 0, 7); hold(8);
    chk(pulses == p0, "R9", pulses, p0);
    step(1, 1, 0, 7); step(1, 1, 1, 7); hold(6);
    step(1, 0, 1, 7); hold(4);

    // mixed random stimulus against the model
    req = "R3";
    seed = $urandom(32'd2024);
    for (int i = 0; i < 6000; i++) begin
      logic na, nb, nc;
      int   nw;
      na = ($urandom_range(5) == 0) ? ~a : a;
      nb = ($urandom_range(5) == 0) ? ~b : b;
      nc = ($urandom_range(24) == 0) ? ~c : c;
      nw = ($urandom_range(15) == 0) ? int'($urandom_range(14)) : int'(w);
      step(na, nb, nc, nw);
    end
    step(1, 0, 1, 3); hold(30);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule